// File: doc/BRIEF.md
# Bufferless Deflection Routing Switch

This block is one tile switch of a two-dimensional network-on-chip. It has four neighbour links, named north, east, south and west, and one local port. On the local port the attached core injects new flits and receives flits addressed to this tile. The switch holds no flit storage and sends no back-pressure to its neighbours. Every flit that arrives in a cycle leaves on some output in the next cycle.

Each flit carries its own destination and is routed alone, so flits of one packet can take different paths and arrive in a different order. Flits are served oldest first. Each flit tries the output ports that bring it closer to its destination. A flit whose useful ports have all been taken by older flits is pushed out of a spare port. It is not held back. Each flit also carries an age field, which the switch raises by one on every pass. Priority by age keeps a flit from circling the network forever.

Parameters choose the grid size, the tile's own coordinates, the field widths, and whether the edges wrap around (torus) or stop (mesh). The network links are packed into flat vectors. Port index 0 is north, 1 is east, 2 is south and 3 is west. North means increasing Y and east means increasing X. Every flit is laid out, from MSB to LSB, as {dstX, dstY, age, payload}.

Top module: `hp_deflect_switch`

## Requirements
- R1: Reset clears every valid output. A flit presented at the inputs appears at the outputs immediately after the next rising clock edge, never later, whatever the load.
- R2: Every valid network input and every accepted injection leaves on exactly one output (a network port or the ejection port) one cycle later. No flit is lost or duplicated.
- R3: A flit that is not addressed to this tile first tries the X port that moves it toward dstX. If dstX already matches, or that port is taken, it tries the Y port that moves it toward dstY.
- R4: A flit whose {dstX,dstY} equals the tile's coordinates leaves on the ejection port. Only one flit ejects per cycle, and the highest-priority such flit is the one chosen. Any other flit addressed to this tile is sent out on a network port.
- R5: Output ports are claimed in priority order. A larger age claims first. On equal age, the lower input index (0 to 3) claims first. An injected flit claims after every network flit of equal age. The flit with top priority always receives a productive port when one exists.
- R6: A flit that gets none of its productive ports (or a flit for this tile that did not eject) takes the lowest-indexed free network port.
- R7: injAccept is high exactly when injValid is high and fewer than four network inputs are valid in the same cycle. The injected flit starts with age 0.
- R8: Every flit leaving the switch, ejected ones included, carries age+1. The age saturates at its all-ones value.
- R9: In torus mode, a flit takes the shorter way round in each dimension. An offset of exactly half the ring goes in the positive direction. In mesh mode, the direction follows the sign of the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| netInValid | input | 4 | Valid bit per neighbour input, index 0..3 = N,E,S,W |
| netInData | input | 4*FW | Neighbour input flits, port p at bits [p*FW +: FW] |
| injValid | input | 1 | Local core offers a flit |
| injData | input | FW-AGE_W | Injected flit without age: {dstX,dstY,payload} |
| injAccept | output | 1 | Injected flit taken this cycle |
| netOutValid | output | 4 | Valid bit per neighbour output |
| netOutData | output | 4*FW | Neighbour output flits, same packing as inputs |
| ejValid | output | 1 | Flit delivered to the local core |
| ejData | output | FW | Delivered flit |

## Verification
Some behaviours are checked by assertions on every clock: flit conservation from input to output, the gate on injection, the tile coordinates of every ejected flit, a nonzero age on every departing flit, and empty outputs after reset. Which port each flit takes cannot be judged one cycle at a time without a full model. This covers priority between competing flits, X-before-Y choice, deflection to the lowest free port, the one-ejector rule, age saturation, and the torus versus mesh direction. The bench therefore drives directed contention cases and a long random run through a behavioural reference model, for a torus and a mesh instance side by side.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int NET_PORTS = 4;
  localparam int CANDS     = NET_PORTS + 1;
  localparam int OUTS      = NET_PORTS + 1;
  localparam int EJECT     = NET_PORTS;
  localparam int INJ       = NET_PORTS;
  localparam int RANK_W    = $clog2(CANDS);

  typedef enum logic [1:0] {
    PORT_N = 2'd0,
    PORT_E = 2'd1,
    PORT_S = 2'd2,
    PORT_W = 2'd3
  } netPort_e;

  typedef logic [NET_PORTS-1:0] portMask_t;

  // grant[c][o]: candidate c leaves on output o (o == EJECT is local)
  typedef struct packed {
    logic [CANDS-1:0][OUTS-1:0] grant;
    logic                       injTake;
  } allocStrobe_t;
endpackage

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
#(
  parameter int GRID_X = 4,
  parameter int GRID_Y = 4,
  parameter int HOME_X = 1,
  parameter int HOME_Y = 2,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int AGE_W  = 3,
  parameter int PAY_W  = 8,
  parameter bit TORUS  = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NET_PORTS-1:0]              netInValid,
  input  logic [NET_PORTS*(X_W+Y_W+AGE_W+PAY_W)-1:0] netInData,
  input  logic                              injValid,
  input  logic [X_W+Y_W+PAY_W-1:0]          injData,
  input  allocStrobe_t                      strobe,
  output logic [CANDS-1:0]                  candValid,
  output logic [CANDS-1:0][AGE_W-1:0]       candAge,
  output logic [CANDS-1:0]                  candHome,
  output portMask_t [CANDS-1:0]             prefA,
  output portMask_t [CANDS-1:0]             prefB,
  output logic [NET_PORTS-1:0]              netOutValid,
  output logic [NET_PORTS*(X_W+Y_W+AGE_W+PAY_W)-1:0] netOutData,
  output logic                              ejValid,
  output logic [X_W+Y_W+AGE_W+PAY_W-1:0]    ejData
);
  localparam int FW = X_W + Y_W + AGE_W + PAY_W;

  logic [CANDS-1:0][FW-1:0] candFlit;

  // candidate assembly: four links, then the injection with a fresh age
  for (genvar p = 0; p < NET_PORTS; p++) begin : g_link
    assign candFlit[p]  = netInData[p*FW +: FW];
    assign candValid[p] = netInValid[p];
  end
  assign candFlit[INJ]  = {injData[X_W+Y_W+PAY_W-1 : PAY_W], {AGE_W{1'b0}}, injData[PAY_W-1:0]};
  assign candValid[INJ] = injValid;

  // per-candidate route preference
  for (genvar c = 0; c < CANDS; c++) begin : g_route
    logic [X_W-1:0] dX;
    logic [Y_W-1:0] dY;
    logic goE, goW, goN, goS;
    portMask_t xMask, yMask;

    assign dX         = candFlit[c][FW-1 -: X_W];
    assign dY         = candFlit[c][FW-X_W-1 -: Y_W];
    assign candAge[c] = candFlit[c][PAY_W +: AGE_W];
    assign candHome[c] = (int'(dX) == HOME_X) && (int'(dY) == HOME_Y);

    if (TORUS) begin : g_torus
      int offX, offY;
      always_comb begin
        offX = (int'(dX) + GRID_X - HOME_X) % GRID_X;
        offY = (int'(dY) + GRID_Y - HOME_Y) % GRID_Y;
        goE  = (offX != 0) && (2 * offX <= GRID_X);
        goW  = (offX != 0) && !(2 * offX <= GRID_X);
        goN  = (offY != 0) && (2 * offY <= GRID_Y);
        goS  = (offY != 0) && !(2 * offY <= GRID_Y);
      end
    end else begin : g_mesh
      assign goE = int'(dX) > HOME_X;
      assign goW = int'(dX) < HOME_X;
      assign goN = int'(dY) > HOME_Y;
      assign goS = int'(dY) < HOME_Y;
    end

    assign xMask = goE ? (portMask_t'(1) << PORT_E) :
                   goW ? (portMask_t'(1) << PORT_W) : '0;
    assign yMask = goN ? (portMask_t'(1) << PORT_N) :
                   goS ? (portMask_t'(1) << PORT_S) : '0;
    assign prefA[c] = (xMask != '0) ? xMask : yMask;
    assign prefB[c] = (xMask != '0) ? yMask : '0;
  end

  function automatic logic [FW-1:0] bumpAge(input logic [FW-1:0] f);
    logic [AGE_W-1:0] a;
    a = f[PAY_W +: AGE_W];
    if (a != {AGE_W{1'b1}}) a = a + AGE_W'(1);
    f[PAY_W +: AGE_W] = a;
    return f;
  endfunction

  logic [OUTS-1:0]          nxtValid, curValid;
  logic [OUTS-1:0][FW-1:0]  nxtFlit, curFlit;

  always_comb begin
    for (int o = 0; o < OUTS; o++) begin
      nxtValid[o] = 1'b0;
      nxtFlit[o]  = '0;
      for (int c = 0; c < CANDS; c++) begin
        if (strobe.grant[c][o]) begin
          nxtValid[o] = 1'b1;
          nxtFlit[o]  = bumpAge(candFlit[c]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curValid <= '0;
      curFlit  <= '0;
    end else begin
      curValid <= nxtValid;
      curFlit  <= nxtFlit;
    end
  end

  for (genvar p = 0; p < NET_PORTS; p++) begin : g_out
    assign netOutValid[p]          = curValid[p];
    assign netOutData[p*FW +: FW]  = curFlit[p];
  end
  assign ejValid = curValid[EJECT];
  assign ejData  = curFlit[EJECT];
endmodule

// File: rtl/hp_control.sv
module hp_control
  import hp_pkg::*;
#(
  parameter int AGE_W = 3
) (
  input  logic [CANDS-1:0]            candValid,
  input  logic [CANDS-1:0][AGE_W-1:0] candAge,
  input  logic [CANDS-1:0]            candHome,
  input  portMask_t [CANDS-1:0]       prefA,
  input  portMask_t [CANDS-1:0]       prefB,
  output allocStrobe_t                strobe
);
  logic [CANDS-1:0]              live;
  logic [CANDS-1:0][RANK_W-1:0]  rankOf;
  logic [CANDS-1:0][OUTS-1:0]    grant;
  logic [OUTS-1:0]               busy;
  logic [OUTS-1:0]               pick;
  portMask_t                     freeNet;

  // injection only when a network port is guaranteed to be spare
  always_comb begin
    live      = candValid;
    live[INJ] = candValid[INJ] &&
                ($countones(candValid[NET_PORTS-1:0]) < NET_PORTS);
  end

  // rank = number of live candidates that beat this one
  always_comb begin
    for (int c = 0; c < CANDS; c++) begin
      rankOf[c] = '0;
      for (int j = 0; j < CANDS; j++) begin
        if (j != c && live[j] &&
            (candAge[j] > candAge[c] || (candAge[j] == candAge[c] && j < c)))
          rankOf[c] = rankOf[c] + RANK_W'(1);
      end
    end
  end

  // serve candidates in rank order, each taking the best still-free output
  always_comb begin
    busy    = '0;
    grant   = '0;
    pick    = '0;
    freeNet = '0;
    for (int r = 0; r < CANDS; r++) begin
      for (int c = 0; c < CANDS; c++) begin
        if (live[c] && rankOf[c] == RANK_W'(r)) begin
          freeNet = ~busy[NET_PORTS-1:0];
          if (candHome[c] && !busy[EJECT])
            pick = OUTS'(1) << EJECT;
          else if ((prefA[c] & freeNet) != '0)
            pick = {1'b0, prefA[c]};
          else if ((prefB[c] & freeNet) != '0)
            pick = {1'b0, prefB[c]};
          else
            pick = {1'b0, freeNet & (~freeNet + portMask_t'(1))};
          grant[c] = pick;
          busy     = busy | pick;
        end
      end
    end
  end

  assign strobe.grant   = grant;
  assign strobe.injTake = live[INJ];
endmodule

// File: rtl/hp_deflect_switch.sv
module hp_deflect_switch
  import hp_pkg::*;
#(
  parameter int GRID_X = 4,
  parameter int GRID_Y = 4,
  parameter int HOME_X = 1,
  parameter int HOME_Y = 2,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int AGE_W  = 3,
  parameter int PAY_W  = 8,
  parameter bit TORUS  = 1'b1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [3:0]                           netInValid,
  input  logic [4*(X_W+Y_W+AGE_W+PAY_W)-1:0]   netInData,
  input  logic                                 injValid,
  input  logic [X_W+Y_W+PAY_W-1:0]             injData,
  output logic                                 injAccept,
  output logic [3:0]                           netOutValid,
  output logic [4*(X_W+Y_W+AGE_W+PAY_W)-1:0]   netOutData,
  output logic                                 ejValid,
  output logic [X_W+Y_W+AGE_W+PAY_W-1:0]       ejData
);
  allocStrobe_t                  strobe;
  logic [CANDS-1:0]              candValid;
  logic [CANDS-1:0][AGE_W-1:0]   candAge;
  logic [CANDS-1:0]              candHome;
  portMask_t [CANDS-1:0]         prefA;
  portMask_t [CANDS-1:0]         prefB;

  hp_datapath #(
    .GRID_X(GRID_X), .GRID_Y(GRID_Y), .HOME_X(HOME_X), .HOME_Y(HOME_Y),
    .X_W(X_W), .Y_W(Y_W), .AGE_W(AGE_W), .PAY_W(PAY_W), .TORUS(TORUS)
  ) u_dp (
    .clk(clk), .rst(rst),
    .netInValid(netInValid), .netInData(netInData),
    .injValid(injValid), .injData(injData),
    .strobe(strobe),
    .candValid(candValid), .candAge(candAge), .candHome(candHome),
    .prefA(prefA), .prefB(prefB),
    .netOutValid(netOutValid), .netOutData(netOutData),
    .ejValid(ejValid), .ejData(ejData)
  );

  hp_control #(.AGE_W(AGE_W)) u_ctl (
    .candValid(candValid), .candAge(candAge), .candHome(candHome),
    .prefA(prefA), .prefB(prefB), .strobe(strobe)
  );

  assign injAccept = strobe.injTake;
endmodule

// File: rtl/hp_deflect_switch_chk.sv
module hp_deflect_switch_chk #(
  parameter int HOME_X = 1,
  parameter int HOME_Y = 2,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int AGE_W  = 3,
  parameter int PAY_W  = 8
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [3:0]                           netInValid,
  input logic                                 injValid,
  input logic                                 injAccept,
  input logic [3:0]                           netOutValid,
  input logic [4*(X_W+Y_W+AGE_W+PAY_W)-1:0]   netOutData,
  input logic                                 ejValid,
  input logic [X_W+Y_W+AGE_W+PAY_W-1:0]       ejData
);
  localparam int FW = X_W + Y_W + AGE_W + PAY_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (netOutValid == 4'b0 && !ejValid));

  // R2
  flit_conserve_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(netOutValid) + int'(ejValid)) ==
                    $past($countones(netInValid) + int'(injAccept)));

  // R4
  eject_home_chk: assert property (@(posedge clk) disable iff (rst)
    ejValid |-> (int'(ejData[FW-1 -: X_W]) == HOME_X &&
                 int'(ejData[FW-X_W-1 -: Y_W]) == HOME_Y));

  // R7
  inject_gate_chk: assert property (@(posedge clk) disable iff (rst)
    injAccept |-> (injValid && $countones(netInValid) < 4));

  // R8
  eject_age_chk: assert property (@(posedge clk) disable iff (rst)
    ejValid |-> ejData[PAY_W +: AGE_W] != '0);

  for (genvar p = 0; p < 4; p++) begin : g_port
    // R8
    out_age_chk: assert property (@(posedge clk) disable iff (rst)
      netOutValid[p] |-> netOutData[p*FW + PAY_W +: AGE_W] != '0);
  end
endmodule

bind hp_deflect_switch hp_deflect_switch_chk #(
  .HOME_X(HOME_X), .HOME_Y(HOME_Y), .X_W(X_W), .Y_W(Y_W),
  .AGE_W(AGE_W), .PAY_W(PAY_W)
) u_chk (.*);

// File: tb/tb_hp_deflect_switch.sv
module tb_hp_deflect_switch;
  localparam int GX = 4, GY = 4, HX = 1, HY = 2;
  localparam int XW = 2, YW = 2, AW = 3, PW = 8;
  localparam int FW = XW + YW + AW + PW;
  localparam int IW = XW + YW + PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]    inV = '0;
  logic [FW-1:0] inD [4];
  logic          iV = 1'b0;
  logic [IW-1:0] iD = '0;
  logic [4*FW-1:0] inBus;
  assign inBus = {inD[3], inD[2], inD[1], inD[0]};

  logic          accT, accM, ejVT, ejVM;
  logic [3:0]    ovT, ovM;
  logic [4*FW-1:0] odT, odM;
  logic [FW-1:0] ejDT, ejDM;

  hp_deflect_switch #(.GRID_X(GX), .GRID_Y(GY), .HOME_X(HX), .HOME_Y(HY),
    .X_W(XW), .Y_W(YW), .AGE_W(AW), .PAY_W(PW), .TORUS(1'b1)) dut (
    .clk(clk), .rst(rst), .netInValid(inV), .netInData(inBus),
    .injValid(iV), .injData(iD), .injAccept(accT),
    .netOutValid(ovT), .netOutData(odT), .ejValid(ejVT), .ejData(ejDT));

  hp_deflect_switch #(.GRID_X(GX), .GRID_Y(GY), .HOME_X(HX), .HOME_Y(HY),
    .X_W(XW), .Y_W(YW), .AGE_W(AW), .PAY_W(PW), .TORUS(1'b0)) dutMesh (
    .clk(clk), .rst(rst), .netInValid(inV), .netInData(inBus),
    .injValid(iV), .injData(iD), .injAccept(accM),
    .netOutValid(ovM), .netOutData(odM), .ejValid(ejVM), .ejData(ejDM));

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input int x, input int y, input int a, input int p);
    logic [FW-1:0] f;
    f = {XW'(x), YW'(y), AW'(a), PW'(p)};
    return f;
  endfunction

  // direction of travel in one dimension: +1, -1 or 0
  function automatic int dirOf(input bit torus, input int dst, input int home, input int size);
    int off;
    if (dst == home) return 0;
    if (!torus) return (dst > home) ? 1 : -1;
    off = (dst - home + size) % size;
    return (2 * off <= size) ? 1 : -1;
  endfunction

  // behavioural reference: sort by age, then hand out ports one by one
  task automatic refRoute(input bit torus, output logic [3:0] ov, output logic [FW-1:0] od [4],
                          output bit ev, output logic [FW-1:0] ed, output bit acc);
    logic [FW-1:0] f [5];
    bit live [5];
    bit used [4];
    int order [$];
    int best, bx, by, dx, dy, a, port;
    int want [$];
    acc = iV && ($countones(inV) < 4);
    for (int i = 0; i < 4; i++) begin
      f[i] = inD[i]; live[i] = inV[i]; used[i] = 1'b0; od[i] = '0;
    end
    f[4] = {iD[IW-1:PW], AW'(0), iD[PW-1:0]};
    live[4] = acc;
    ov = '0; ev = 1'b0; ed = '0;
    for (int k = 0; k < 5; k++) begin
      best = -1;
      for (int i = 0; i < 5; i++)
        if (live[i] && (best < 0 || f[i][PW +: AW] > f[best][PW +: AW])) best = i;
      if (best < 0) break;
      order.push_back(best);
      live[best] = 1'b0;
    end
    foreach (order[n]) begin
      int c = order[n];
      logic [FW-1:0] g = f[c];
      a = int'(g[PW +: AW]);
      if (a < (1 << AW) - 1) g[PW +: AW] = AW'(a + 1);
      bx = int'(g[FW-1 -: XW]);
      by = int'(g[FW-XW-1 -: YW]);
      if (bx == HX && by == HY && !ev) begin
        ev = 1'b1; ed = g;
        continue;
      end
      dx = dirOf(torus, bx, HX, GX);
      dy = dirOf(torus, by, HY, GY);
      want.delete();
      if (dx == 1) want.push_back(1);
      if (dx == -1) want.push_back(3);
      if (dy == 1) want.push_back(0);
      if (dy == -1) want.push_back(2);
      port = -1;
      foreach (want[w]) if (port < 0 && !used[want[w]]) port = want[w];
      for (int p = 0; p < 4; p++) if (port < 0 && !used[p]) port = p;
      used[port] = 1'b1;
      ov[port] = 1'b1;
      od[port] = g;
    end
  endtask

  // called at a falling edge with inputs set; compares one cycle later
  task automatic step(input string tag);
    logic [3:0] eovT, eovM;
    logic [FW-1:0] eodT [4];
    logic [FW-1:0] eodM [4];
    bit eevT, eevM, eaccT, eaccM;
    logic [FW-1:0] eedT, eedM;
    refRoute(1'b1, eovT, eodT, eevT, eedT, eaccT);
    refRoute(1'b0, eovM, eodM, eevM, eedM, eaccM);
    #1;
    chk(accT == eaccT, tag, "injAccept torus", 64'(accT), 64'(eaccT));
    chk(accM == eaccM, tag, "injAccept mesh", 64'(accM), 64'(eaccM));
    @(negedge clk);
    chk(ovT == eovT, tag, "netOutValid torus", 64'(ovT), 64'(eovT));
    chk(ovM == eovM, tag, "netOutValid mesh", 64'(ovM), 64'(eovM));
    for (int p = 0; p < 4; p++) begin
      chk(odT[p*FW +: FW] == eodT[p], tag, $sformatf("torus port %0d data", p),
          64'(odT[p*FW +: FW]), 64'(eodT[p]));
      chk(odM[p*FW +: FW] == eodM[p], tag, $sformatf("mesh port %0d data", p),
          64'(odM[p*FW +: FW]), 64'(eodM[p]));
    end
    chk(ejVT == eevT && ejDT == eedT, tag, "eject torus", {ejVT, 48'(ejDT)}, {eevT, 48'(eedT)});
    chk(ejVM == eevM && ejDM == eedM, tag, "eject mesh", {ejVM, 48'(ejDM)}, {eevM, 48'(eedM)});
  endtask

  task automatic clearIn();
    inV = '0; iV = 1'b0; iD = '0;
    for (int i = 0; i < 4; i++) inD[i] = '0;
  endtask

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    // R1: outputs empty while in reset
    chk(ovT == 4'b0 && !ejVT && ovM == 4'b0 && !ejVM, "R1", "reset outputs",
        64'({ovT, ejVT}), 64'(0));
    rst = 1'b0;

    // R1, R3: lone flit from west to (3,3) goes east first, one cycle later
    inV = 4'b1000; inD[3] = mk(3, 3, 0, 'hA5);
    step("R1");
    chk(ovT == 4'b0010 && odT[1*FW +: FW] == mk(3, 3, 1, 'hA5), "R3", "X first",
        64'(odT[1*FW +: FW]), 64'(mk(3, 3, 1, 'hA5)));
    // R3: X already matches, go north
    inD[3] = mk(1, 3, 0, 'h11);
    step("R3");
    chk(ovT == 4'b0001, "R3", "Y when X done", 64'(ovT), 64'(4'b0001));

    // R9: dstY=0 from HY=2 is half the ring: torus goes north, mesh goes south
    inD[3] = mk(1, 0, 0, 'h22);
    step("R9");
    chk(ovT == 4'b0001, "R9", "torus half ring north", 64'(ovT), 64'(4'b0001));
    chk(ovM == 4'b0100, "R9", "mesh south", 64'(ovM), 64'(4'b0100));

    // R5, R6: older flit from south wins east, north flit deflected to port 0
    inV = 4'b0101; inD[0] = mk(3, 2, 2, 'h01); inD[2] = mk(3, 2, 5, 'h02);
    step("R5");
    chk(odT[1*FW +: FW] == mk(3, 2, 6, 'h02), "R5", "older wins east",
        64'(odT[1*FW +: FW]), 64'(mk(3, 2, 6, 'h02)));
    chk(odT[0*FW +: FW] == mk(3, 2, 3, 'h01), "R6", "loser to lowest free",
        64'(odT[0*FW +: FW]), 64'(mk(3, 2, 3, 'h01)));
    // R5: equal age, lower index wins
    inD[0] = mk(3, 2, 3, 'h03); inD[2] = mk(3, 2, 3, 'h04);
    step("R5");
    chk(odT[1*FW +: FW] == mk(3, 2, 4, 'h03), "R5", "tie to lower index",
        64'(odT[1*FW +: FW]), 64'(mk(3, 2, 4, 'h03)));

    // R4: two flits for this tile, older one ejects, other deflected
    inV = 4'b1010; inD[0] = '0; inD[2] = '0;
    inD[1] = mk(HX, HY, 1, 'h33); inD[3] = mk(HX, HY, 4, 'h44);
    step("R4");
    chk(ejVT && ejDT == mk(HX, HY, 5, 'h44), "R4", "oldest ejects",
        64'(ejDT), 64'(mk(HX, HY, 5, 'h44)));
    chk(ovT == 4'b0001 && odT[0 +: FW] == mk(HX, HY, 2, 'h33), "R4", "second deflected",
        64'(odT[0 +: FW]), 64'(mk(HX, HY, 2, 'h33)));

    // R7: injection refused with four valid inputs, taken with three
    inV = 4'b1111;
    for (int i = 0; i < 4; i++) inD[i] = mk(3, 3, i, 'h50 + i);
    iV = 1'b1; iD = {2'd0, 2'd2, 8'h77};
    step("R7");
    inV = 4'b0111;
    step("R7");

    // R8: age saturates
    clearIn();
    inV = 4'b0001; inD[0] = mk(3, 1, 7, 'h99);
    step("R8");
    chk(odT[1*FW +: FW] == mk(3, 1, 7, 'h99), "R8", "age saturates",
        64'(odT[1*FW +: FW]), 64'(mk(3, 1, 7, 'h99)));

    // R2: random traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      inV = 4'($urandom);
      for (int i = 0; i < 4; i++) inD[i] = FW'($urandom);
      iV = 1'($urandom);
      iD = IW'($urandom);
      step("R2");
    end

    clearIn();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule